// File: doc/BRIEF.md
# Infrared UART Flow-Control Register Bank

This block keeps the settings that an infrared UART applies at the moment it falls back from a fast infrared mode (MIR or FIR) to SIR. Software loads four things ahead of time: a 16-bit fallback baud divisor, a fallback handshake mode, a DMA direction and a set of per-part enables. When the UART raises the single-cycle `fc_evt` pulse for that mode drop, the block copies the enabled parts into its working registers. The working registers are the active baud divisor, the active 3-bit handshake mode and the DMA enable and direction.

Software reaches every register through a plain byte-wide bus made of an address, a write strobe, write data and combinational read data. The bus has no stall or handshake: a write completes on the clock edge where `wr_en` is high. The working registers can also be written directly through the bus. When a write and a copy target the same field on the same edge, the copy takes effect.

Address map:

| Address | Register |
|---|---|
| 0 | Fallback divisor, low byte |
| 1 | Fallback divisor, high byte |
| 2 | Control register |
| 3 | Register-set select |
| 4 | Active divisor, low byte |
| 5 | Active divisor, high byte |
| 6 | Active state |
| 7 | Reads 0, writes are ignored |

Top module: `fc_irda_regs`

## Requirements
- R1: After reset, `adv_div`, `adv_mode`, `dma_en`, `dma_dir` and `reg_set` are all 0, and addresses 0, 1, 2, 4, 5 and 6 read back 0.
- R2: A write to address 0 or 1 stores the low or high fallback divisor byte, which then reads back unchanged. A write to address 2 stores the control register, whose bits are: 7..5 fallback mode, 4 reserved, 3 DMA direction select, 2 DMA enable, 1 divisor copy enable, 0 master enable.
- R3: Bit 4 of the control register always reads 0, and a write of 1 to that bit has no effect.
- R4: A write to address 3 drives `reg_set` with the written byte on the next cycle. A read of address 3 always returns 0xEC.
- R5: Writes to addresses 4 and 5 set the low and high bytes of `adv_div`. A write to address 6 sets `adv_mode` from bits 2..0, `dma_dir` from bit 3 and `dma_en` from bit 4. Address 6 reads back {3'b000, dma_en, dma_dir, adv_mode}.
- R6: When `fc_evt` is high and the master enable is 0, `adv_div`, `adv_mode`, `dma_en` and `dma_dir` do not change.
- R7: When `fc_evt` is high with the master enable set, `adv_div` takes {high byte, low byte} of the fallback divisor on the next cycle if the divisor copy enable is 1. It keeps its value if the divisor copy enable is 0.
- R8: When `fc_evt` is high with the master enable set, `adv_mode` takes the fallback mode field on the next cycle.
- R9: When `fc_evt` is high with the master enable and the DMA enable set, `dma_en` becomes 1 and `dma_dir` takes the direction select bit on the next cycle (0 = receiver, 1 = transmitter). With the DMA enable at 0, both keep their values.
- R10: If a bus write to a working field lands on the same edge as a copy into that field, the copied value is kept. A write to a field that the copy does not touch still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe; the write happens on the clock edge where it is high |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| fc_evt | input | 1 | Single-cycle pulse marking a drop from fast infrared to SIR |
| adv_div | output | 16 | Active baud divisor |
| adv_mode | output | 3 | Active handshake mode |
| dma_en | output | 1 | DMA use allowed |
| dma_dir | output | 1 | DMA direction: 0 receiver, 1 transmitter |
| reg_set | output | 8 | Last value written to the register-set select |

## Verification
The assertions assume that `fc_evt` lasts a single cycle and that the fallback settings it samples are the values present on that edge. Under that assumption, each copy check compares a working register with the previous-cycle value of its fallback register. The stable-hold check only applies on edges where the bus does not also write a working register. The bench raises the event for exactly one cycle, keeps it separate from fallback-register writes, and combines it with a working-register write only in the scenario that tests the collision rule.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_FB_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FB_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_SETSEL = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACT_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACT_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_ACT_ST = 3'd6;

  typedef struct packed {
    logic [MODE_W-1:0] fb_mode;
    logic              rsvd;
    logic              dir_sel;
    logic              dma_on;
    logic              div_on;
    logic              master;
  } fc_ctrl_t;
endpackage

// File: rtl/fcr_shadow.sv
module fcr_shadow
  import fcr_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic          we_ctrl,
  input  logic [BW-1:0] wd,
  output logic [BW-1:0] fb_lo,
  output logic [BW-1:0] fb_hi,
  output fc_ctrl_t      ctrl
);
  fc_ctrl_t ctrl_in;

  always_comb begin
    ctrl_in      = fc_ctrl_t'(wd);
    ctrl_in.rsvd = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_lo <= '0;
      fb_hi <= '0;
      ctrl  <= '0;
    end else begin
      if (we_lo)   fb_lo <= wd;
      if (we_hi)   fb_hi <= wd;
      if (we_ctrl) ctrl  <= ctrl_in;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    we_ctrl |=> ctrl.rsvd == 1'b0); // R3
endmodule

// File: rtl/fcr_active.sv
module fcr_active
  import fcr_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int MW = MODE_W,
  localparam int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  fc_ctrl_t      ctrl,
  input  logic [BW-1:0] fb_lo,
  input  logic [BW-1:0] fb_hi,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic          we_st,
  input  logic [BW-1:0] wd,
  output logic [DW-1:0] div,
  output logic [MW-1:0] mode,
  output logic          dma_en,
  output logic          dma_dir
);
  logic copy, ld_div, ld_dma;

  assign copy   = evt & ctrl.master;
  assign ld_div = copy & ctrl.div_on;
  assign ld_dma = copy & ctrl.dma_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div     <= '0;
      mode    <= '0;
      dma_en  <= 1'b0;
      dma_dir <= 1'b0;
    end else begin
      if (ld_div) begin
        div <= {fb_hi, fb_lo};
      end else begin
        if (we_lo) div[BW-1:0]  <= wd;
        if (we_hi) div[DW-1:BW] <= wd;
      end
      if (copy)       mode <= ctrl.fb_mode;
      else if (we_st) mode <= wd[MW-1:0];
      if (ld_dma) begin
        dma_en  <= 1'b1;
        dma_dir <= ctrl.dir_sel;
      end else if (we_st) begin
        dma_dir <= wd[MW];
        dma_en  <= wd[MW+1];
      end
    end
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !ctrl.master && !we_lo && !we_hi && !we_st)
      |=> ($stable(div) && $stable(mode) && $stable(dma_en) && $stable(dma_dir))); // R6
  AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ctrl.master && ctrl.div_on) |=> div == $past({fb_hi, fb_lo})); // R7
  AST_DIV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ctrl.master && !ctrl.div_on && !we_lo && !we_hi) |=> $stable(div)); // R7
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ctrl.master) |=> mode == $past(ctrl.fb_mode)); // R8
  AST_DMA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ctrl.master && ctrl.dma_on) |=> (dma_en && dma_dir == $past(ctrl.dir_sel))); // R9
  AST_COPY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && ctrl.master && we_st) |=> mode == $past(ctrl.fb_mode)); // R10
endmodule

// File: rtl/fc_irda_regs.sv
module fc_irda_regs
  import fcr_pkg::*;
#(
  parameter int               BW       = BYTE_W,
  parameter int               MW       = MODE_W,
  parameter int               AW       = ADDR_W,
  parameter logic [BYTE_W-1:0] SET_RD  = 8'hEC,
  localparam int              DW       = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] rd_data,
  input  logic          fc_evt,
  output logic [DW-1:0] adv_div,
  output logic [MW-1:0] adv_mode,
  output logic          dma_en,
  output logic          dma_dir,
  output logic [BW-1:0] reg_set
);
  logic [BW-1:0] fb_lo, fb_hi;
  fc_ctrl_t      ctrl;
  logic          we_fl, we_fh, we_ct, we_ss, we_al, we_ah, we_as;

  assign we_fl = wr_en && addr == A_FB_LO;
  assign we_fh = wr_en && addr == A_FB_HI;
  assign we_ct = wr_en && addr == A_CTRL;
  assign we_ss = wr_en && addr == A_SETSEL;
  assign we_al = wr_en && addr == A_ACT_LO;
  assign we_ah = wr_en && addr == A_ACT_HI;
  assign we_as = wr_en && addr == A_ACT_ST;

  fcr_shadow #(.BW(BW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .we_lo(we_fl), .we_hi(we_fh), .we_ctrl(we_ct),
    .wd(wr_data), .fb_lo(fb_lo), .fb_hi(fb_hi), .ctrl(ctrl)
  );

  fcr_active #(.BW(BW), .MW(MW)) u_active (
    .clk(clk), .rst_n(rst_n), .evt(fc_evt), .ctrl(ctrl), .fb_lo(fb_lo),
    .fb_hi(fb_hi), .we_lo(we_al), .we_hi(we_ah), .we_st(we_as), .wd(wr_data),
    .div(adv_div), .mode(adv_mode), .dma_en(dma_en), .dma_dir(dma_dir)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     reg_set <= '0;
    else if (we_ss) reg_set <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_FB_LO:  rd_data = fb_lo;
      A_FB_HI:  rd_data = fb_hi;
      A_CTRL:   rd_data = ctrl;
      A_SETSEL: rd_data = SET_RD;
      A_ACT_LO: rd_data = adv_div[BW-1:0];
      A_ACT_HI: rd_data = adv_div[DW-1:BW];
      A_ACT_ST: rd_data = BW'({dma_en, dma_dir, adv_mode});
      default:  rd_data = '0;
    endcase
  end

  AST_SET_READ: assert property (@(posedge clk) disable iff (!rst_n)
    addr == A_SETSEL |-> rd_data == SET_RD); // R4
  AST_RSVD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    addr == A_CTRL |-> rd_data[4] == 1'b0); // R3
endmodule

// File: tb/tb_fc_irda_regs.sv
`timescale 1ns/1ps
module tb_fc_irda_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        fc_evt = 1'b0;
  logic [15:0] adv_div;
  logic [2:0]  adv_mode;
  logic        dma_en, dma_dir;
  logic [7:0]  reg_set;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fc_irda_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .fc_evt(fc_evt), .adv_div(adv_div), .adv_mode(adv_mode),
    .dma_en(dma_en), .dma_dir(dma_dir), .reg_set(reg_set)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic ev);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; fc_evt = ev;
    @(negedge clk);
    wr_en = 1'b0; fc_evt = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    fc_evt = 1'b1;
    @(negedge clk);
    fc_evt = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 div", adv_div, 0); chk("R1 mode", adv_mode, 0);
    chk("R1 dma", {dma_en, dma_dir}, 0); chk("R1 set", reg_set, 0);
    for (int a = 0; a < 7; a++) begin
      if (a != 3) begin rd(a[2:0], d); chk("R1 read", d, 0); end
    end
  endtask

  task automatic t_shadow();
    logic [7:0] d;
    wr(0, 8'h5A, 0); wr(1, 8'hC3, 0); wr(2, 8'hE6, 0);
    rd(0, d); chk("R2 lo", d, 8'h5A);
    rd(1, d); chk("R2 hi", d, 8'hC3);
    rd(2, d); chk("R2 ctrl", d, 8'hE6);
    wr(2, 8'hFF, 0);
    rd(2, d); chk("R3 reserved", d, 8'hEF);
    wr(2, 8'h00, 0);
  endtask

  task automatic t_setsel();
    logic [7:0] d;
    wr(3, 8'h07, 0);
    chk("R4 reg_set", reg_set, 8'h07);
    rd(3, d); chk("R4 read", d, 8'hEC);
  endtask

  task automatic t_active();
    logic [7:0] d;
    wr(4, 8'h11, 0); wr(5, 8'h22, 0); wr(6, 8'h1D, 0);
    chk("R5 div", adv_div, 16'h2211);
    chk("R5 mode", adv_mode, 3'd5);
    chk("R5 dma", {dma_en, dma_dir}, 2'b11);
    rd(6, d); chk("R5 read", d, 8'h1D);
    wr(6, 8'h00, 0);
  endtask

  task automatic t_off();
    wr(0, 8'h34, 0); wr(1, 8'h12, 0); wr(2, 8'hEE, 0);
    pulse();
    chk("R6 div", adv_div, 16'h2211);
    chk("R6 mode", adv_mode, 0);
    chk("R6 dma", {dma_en, dma_dir}, 0);
  endtask

  task automatic t_full();
    wr(2, 8'hAF, 0);
    pulse();
    chk("R7 div", adv_div, 16'h1234);
    chk("R8 mode", adv_mode, 3'd5);
    chk("R9 dma", {dma_en, dma_dir}, 2'b11);
  endtask

  task automatic t_partial();
    wr(6, 8'h00, 0); wr(4, 8'h99, 0);
    wr(2, 8'h61, 0);
    pulse();
    chk("R7 keep", adv_div, 16'h1299);
    chk("R8 mode", adv_mode, 3'd3);
    chk("R9 keep", {dma_en, dma_dir}, 2'b00);
    wr(2, 8'h05, 0);
    pulse();
    chk("R9 rx", {dma_en, dma_dir}, 2'b10);
    chk("R8 zero", adv_mode, 0);
  endtask

  task automatic t_collide();
    wr(2, 8'h43, 0);
    wr(4, 8'h55, 1);
    chk("R10 div", adv_div, 16'h1234);
    wr(6, 8'h1F, 1);
    chk("R10 mode", adv_mode, 3'd2);
    chk("R10 dma", {dma_en, dma_dir}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_shadow(); t_setsel(); t_active();
    t_off(); t_full(); t_partial(); t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule